// File: doc/BRIEF.md
# I/O Port Breakpoint Checker

This block watches port I/O accesses and compares each one against four debug breakpoint slots. A slot takes part only when the debug control word marks it as an I/O breakpoint and enables it, either locally or globally. An access is described by its first port, a size code (1, 2 or 4 bytes) and the address of the instruction that follows it. The check is a range-overlap test between the bytes the access touches and the bytes the slot covers. It is not an equality compare, so an access that only partly covers a slot still hits.

When one or more slots hit, the block does three things one clock after the access is sampled. It produces a new debug status word, in which the low four bits are replaced by the hit mask and the upper bits are taken from the current status. It loads the resume address with the next-instruction address, so that execution continues after the I/O instruction. It pulses the trap strobe for one cycle. When nothing hits, or when checking is switched off, the outputs keep their previous values. The I/O transaction itself is handled elsewhere.

Top module: `io_bkpt_checker`

## Requirements
- R1: Slot i takes part only when both of these hold. Its type field `dbg_ctrl[16+4i +: 2]` equals 2'b10 (I/O). At least one of its enables is set: local `dbg_ctrl[2i]` or global `dbg_ctrl[2i+1]`. Any slot that does not qualify never hits.
- R2: A qualifying slot hits when both of these hold. The last accessed port (port + bytes − 1) is at or above the slot address. The first accessed port is at or below the slot address + slot length − 1.
- R3: The slot length field `dbg_ctrl[18+4i +: 2]` decodes as follows: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 8 bytes, 3 gives 4 bytes.
- R4: The access size code `acc_size` decodes as follows: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. Code 3 is treated as 4 bytes.
- R5: Bit i of the hit mask belongs to slot i. Every slot that hits sets its own bit, so several bits can be set at once.
- R6: A hit is sampled on a clock edge. In the cycle after that edge, `status_o` equals `status_in` with its low four bits replaced by the hit mask.
- R7: In that same cycle, `resume_ip_o` equals the `acc_next_ip` that was sampled, and `trap_o` is high. `trap_o` is high only in cycles that follow a sampled hit.
- R8: After a sampled access that hits no slot, `trap_o` is low, and `status_o` and `resume_ip_o` keep their previous values.
- R9: When `chk_active` or `acc_valid` is low at an edge, nothing is checked. `trap_o` is low afterwards, and `status_o` and `resume_ip_o` keep their values.
- R10: Port ranges are compared in 17-bit arithmetic, so an access running past port 0xFFFF does not wrap around to low ports.
- R11: While `rst_n` is low, `trap_o`, `status_o` and `resume_ip_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_active | input | 1 | I/O breakpoint checking enabled |
| acc_valid | input | 1 | A port access is presented this cycle |
| acc_port | input | 16 | First port of the access |
| acc_size | input | 2 | Access size code (R4) |
| acc_next_ip | input | 32 | Address of the instruction after the access |
| dbg_ctrl | input | 32 | Debug control word: enables, types, lengths |
| slot_addr | input | 64 | Four 16-bit slot addresses, slot i at bits [16i +: 16] |
| status_in | input | 32 | Current debug status word |
| trap_o | output | 1 | One-cycle debug trap request |
| status_o | output | 32 | Updated debug status word |
| resume_ip_o | output | 32 | Address at which execution resumes |

## Verification
The overlap test is tried with accesses that sit one port before, exactly on and one port past each slot edge. These patterns separate a correct inclusive range test from an off-by-one error or a plain equality compare. Each of the four slot length codes and each of the four size codes is used at least once, so a swapped 4-byte/8-byte decode shows up as a hit or miss at the far edge. The cases that decide which slots are examined are a slot of the wrong type, a disabled slot, a slot enabled only by its global bit, and the checker switched off. An access at port 0xFFFF with a wide size, together with a slot at the bottom of the port space, separates 17-bit arithmetic from wrapping. An access spanning two adjacent slots shows that the hit mask collects every matching slot.

// File: rtl/io_bkpt_checker.sv
module io_bkpt_checker #(
  parameter int NSLOT  = 4,
  parameter int PORT_W = 16,
  parameter int IP_W   = 32,
  parameter int REG_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chk_active,
  input  logic                    acc_valid,
  input  logic [PORT_W-1:0]       acc_port,
  input  logic [1:0]              acc_size,
  input  logic [IP_W-1:0]         acc_next_ip,
  input  logic [REG_W-1:0]        dbg_ctrl,
  input  logic [NSLOT*PORT_W-1:0] slot_addr,
  input  logic [REG_W-1:0]        status_in,
  output logic                    trap_o,
  output logic [REG_W-1:0]        status_o,
  output logic [IP_W-1:0]         resume_ip_o
);

  localparam int CW = PORT_W + 1;
  localparam int TYPE_BASE = 16;
  localparam logic [1:0] TYPE_IO = 2'b10;

  logic [NSLOT-1:0] slot_on;
  logic [NSLOT-1:0] slot_hit;
  logic [CW-1:0]    acc_bytes;
  logic [CW-1:0]    span_lo;
  logic [CW-1:0]    span_hi;
  logic             sample;

  always_comb begin
    case (acc_size)
      2'd0:    acc_bytes = CW'(1);
      2'd1:    acc_bytes = CW'(2);
      default: acc_bytes = CW'(4);
    endcase
  end

  assign span_lo = {1'b0, acc_port};
  assign span_hi = span_lo + acc_bytes - CW'(1);
  assign sample  = chk_active && acc_valid;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [1:0]    kind;
    logic [1:0]    lcode;
    logic [CW-1:0] blen;
    logic [CW-1:0] b_lo;
    logic [CW-1:0] b_hi;

    assign kind  = dbg_ctrl[TYPE_BASE + 4*g +: 2];
    assign lcode = dbg_ctrl[TYPE_BASE + 4*g + 2 +: 2];

    always_comb begin
      case (lcode)
        2'd0:    blen = CW'(1);
        2'd1:    blen = CW'(2);
        2'd2:    blen = CW'(8);
        default: blen = CW'(4);
      endcase
    end

    assign b_lo = {1'b0, slot_addr[g*PORT_W +: PORT_W]};
    assign b_hi = b_lo + blen - CW'(1);

    assign slot_on[g]  = (kind == TYPE_IO) && (dbg_ctrl[2*g] || dbg_ctrl[2*g+1]);
    assign slot_hit[g] = slot_on[g] && (span_hi >= b_lo) && (span_lo <= b_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_o      <= 1'b0;
      status_o    <= '0;
      resume_ip_o <= '0;
    end else begin
      trap_o <= 1'b0;
      if (sample && |slot_hit) begin
        trap_o      <= 1'b1;
        status_o    <= {status_in[REG_W-1:NSLOT], slot_hit};
        resume_ip_o <= acc_next_ip;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{dbg_ctrl[2*NSLOT +: (TYPE_BASE - 2*NSLOT)], status_in[NSLOT-1:0]};

  p_slot_scope_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ((status_o[NSLOT-1:0] & ~$past(slot_on)) == '0));

  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (status_o[NSLOT-1:0] != '0));

  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (status_o[REG_W-1:NSLOT] == $past(status_in[REG_W-1:NSLOT])));

  p_resume_ip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (resume_ip_o == $past(acc_next_ip)));

  p_hold_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> ($stable(status_o) && $stable(resume_ip_o)));

  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_active && acc_valid) |=> !trap_o);

endmodule

// File: tb/test_io_bkpt_checker.sv
module test_io_bkpt_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_active;
  logic        acc_valid;
  logic [15:0] acc_port;
  logic [1:0]  acc_size;
  logic [31:0] acc_next_ip;
  logic [31:0] dbg_ctrl;
  logic [63:0] slot_addr;
  logic [31:0] status_in;
  logic        trap_o;
  logic [31:0] status_o;
  logic [31:0] resume_ip_o;

  always #10ns clk = ~clk;

  io_bkpt_checker i_io_bkpt_checker (
    .clk(clk), .rst_n(rst_n), .chk_active(chk_active), .acc_valid(acc_valid),
    .acc_port(acc_port), .acc_size(acc_size), .acc_next_ip(acc_next_ip),
    .dbg_ctrl(dbg_ctrl), .slot_addr(slot_addr), .status_in(status_in),
    .trap_o(trap_o), .status_o(status_o), .resume_ip_o(resume_ip_o));

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] port;
    logic [1:0]  size;
    logic [3:0]  mask;
  } vec_t;

  // slots: 0x0060 1B, 0x03F8 2B, 0x0CF8 4B (code 3), 0xFFFE 2B, all I/O, local enables
  localparam logic [31:0] CTRL_A = 32'h6E62_0055;
  localparam logic [63:0] ADDRS  = {16'hFFFE, 16'h0CF8, 16'h03F8, 16'h0060};
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{CTRL_A,       16'h0060, 2'd0, 4'b0001},  // R2 exact
    '{CTRL_A,       16'h005F, 2'd1, 4'b0001},  // R2 R4 last port on slot
    '{CTRL_A,       16'h005E, 2'd1, 4'b0000},  // R2 R8 one short
    '{CTRL_A,       16'h0061, 2'd0, 4'b0000},  // R2 one past
    '{CTRL_A,       16'h03F9, 2'd0, 4'b0010},  // R3 2-byte slot end
    '{CTRL_A,       16'h03FA, 2'd0, 4'b0000},  // R3 past 2-byte slot
    '{CTRL_A,       16'h0CF8, 2'd2, 4'b0100},  // R4 4-byte access
    '{CTRL_A,       16'h0CFB, 2'd0, 4'b0100},  // R3 code 3 is 4 bytes
    '{CTRL_A,       16'h0CFC, 2'd0, 4'b0000},  // R3 not 8 bytes
    '{CTRL_A,       16'hFFFF, 2'd2, 4'b1000},  // R10 top of space
    '{CTRL_A,       16'h0000, 2'd2, 4'b0000},  // R10 no wrap
    '{32'h000A_0002, 16'h0067, 2'd0, 4'b0001}, // R3 8-byte, R1 global enable
    '{32'h000A_0002, 16'h0068, 2'd0, 4'b0000}, // R3 past 8 bytes
    '{32'h6E62_0000, 16'h0060, 2'd0, 4'b0000}, // R1 disabled
    '{32'h0001_0001, 16'h0060, 2'd0, 4'b0000}, // R1 wrong type
    '{CTRL_A,       16'h005D, 2'd3, 4'b0001}   // R4 code 3 is 4 bytes
  };

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_status = '0;
  logic [31:0] exp_ip = '0;

  task automatic apply(input logic [31:0] c, input logic [15:0] p, input logic [1:0] s,
                       input logic [3:0] m, input logic act, input string tag);
    logic exp_trap;
    @(negedge clk);
    dbg_ctrl    = c;
    acc_port    = p;
    acc_size    = s;
    chk_active  = act;
    acc_valid   = 1'b1;
    acc_next_ip = 32'h0040_0000 + 32'(n_vec * 3);
    status_in   = 32'h5A5A_0000 | 32'(n_vec << 4) | 32'hF;
    exp_trap    = act && (m != 4'b0);
    if (exp_trap) begin
      exp_status = {status_in[31:4], m};
      exp_ip     = acc_next_ip;
    end
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    n_vec++;
    if (trap_o !== exp_trap || status_o !== exp_status || resume_ip_o !== exp_ip) begin
      n_bad++;
      $display("FAIL %s port=%h: trap/status/ip = %b/%h/%h expected %b/%h/%h", tag, p,
               trap_o, status_o, resume_ip_o, exp_trap, exp_status, exp_ip);
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chk_active = 1'b0; acc_valid = 1'b0; acc_port = '0; acc_size = '0;
    acc_next_ip = '0; dbg_ctrl = '0; slot_addr = ADDRS; status_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (trap_o !== 1'b0 || status_o !== '0 || resume_ip_o !== '0) begin
      n_bad++;
      $display("FAIL R11 reset: %b/%h/%h expected 0/0/0", trap_o, status_o, resume_ip_o);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(VEC[i].ctrl, VEC[i].port, VEC[i].size, VEC[i].mask, 1'b1, "R2 table");

    // R9: checking off, would hit slot 0
    apply(CTRL_A, 16'h0060, 2'd0, 4'b0001, 1'b0, "R9 inactive");

    // R9: valid low, would hit slot 0
    @(negedge clk);
    chk_active = 1'b1; acc_valid = 1'b0; acc_port = 16'h0060; dbg_ctrl = CTRL_A;
    status_in = 32'h1234_5678; acc_next_ip = 32'hDEAD_0000;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (trap_o !== 1'b0 || status_o !== exp_status || resume_ip_o !== exp_ip) begin
      n_bad++;
      $display("FAIL R9 valid low: %b/%h/%h expected 0/%h/%h", trap_o, status_o,
               resume_ip_o, exp_status, exp_ip);
    end

    // R5: one access spans two adjacent slots
    slot_addr = {16'hFFFE, 16'h0CF8, 16'h0102, 16'h0100};
    apply(CTRL_A, 16'h0100, 2'd2, 4'b0011, 1'b1, "R5 multi-hit");
    apply(CTRL_A, 16'h0103, 2'd0, 4'b0010, 1'b1, "R5 second slot only");

    // R10: slot at port 0, access from 0xFFFE must not wrap onto it
    slot_addr = {16'h8000, 16'h0CF8, 16'h03F8, 16'h0000};
    apply(CTRL_A, 16'hFFFE, 2'd2, 4'b0000, 1'b1, "R10 wrap");
    apply(CTRL_A, 16'h0000, 2'd0, 4'b0001, 1'b1, "R10 port zero");

    // R7: trap lasts one cycle when no new access follows
    @(negedge clk);
    n_vec++;
    if (trap_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 strobe width: trap=%b expected 0", trap_o);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule